// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that runs from its own free-running clock. Software controls it by writing 16-bit magic values to one key register. One key value opens the prescaler and reload registers for writing. A second key value services the timer by loading the counter again. A third key value starts the timer. Any other value written to the key register closes write access again.

When the timer is running, a prescaler divides the clock by a power of two from 4 to 256. Each prescaled tick lowers a 12-bit counter by one. When the counter reaches zero, the block raises a reset request and holds it until a system reset. It also sets a reset-cause flag that only a power-on reset clears. Software can read this flag after the restart, and it clears the flag by writing 1 to bit 0 of the status register.

Register map (2-bit address): 0 is the key register, and a read of it returns the live counter value. 1 is the prescaler code in bits [2:0]. 2 is the reload value in bits [11:0]. 3 is the status register: bit 0 is the reset-cause flag, bit 1 shows that the timer is running, and bit 2 shows that writes are open.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on and system reset, the block is in this state: the timer is stopped, the reset request is low, writes are closed, the prescaler code is 0, the reload value is 0xFFF, the counter reads 0xFFF and the status register reads 0.
- R2: Writing 0x5555 to address 0 opens writes and sets status bit 2. While writes are open, writes to address 1 (data bits [2:0]) and to address 2 (data bits [11:0]) take effect and read back.
- R3: Writing any key value other than 0x5555 (0xAAAA and 0xCCCC included) closes writes. While writes are closed, writes to addresses 1 and 2 leave the stored values unchanged.
- R4: Writing 0xCCCC to address 0 sets status bit 1, loads the counter from the reload value and restarts the prescaler phase. While the timer is stopped and no load occurs, the counter holds its value.
- R5: Writing 0xAAAA to address 0 loads the counter from the reload value and restarts the prescaler phase.
- R6: Prescaler code n, for n from 0 to 6, divides the clock by 2^(n+2). Code 7 divides by 256.
- R7: When a load from reload value R with divider D happens on a clock edge and no later load follows, the counter falls by one every D edges. The reset request rises on the edge R*D+1 edges after the load, so a reload value of 0 gives a request on the next edge.
- R8: No key write stops a running timer. Once raised, the reset request stays high until a system reset.
- R9: The reset-cause flag (status bit 0) sets on the edge where the reset request rises. A system reset does not clear it.
- R10: Writing address 3 with data bit 0 set clears the flag, and writing with bit 0 clear has no effect. A power-on reset also clears the flag. If the flag is set and cleared on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running watchdog clock |
| rstSysN | input | 1 | Active-low asynchronous system reset (stops the timer) |
| rstPorN | input | 1 | Active-low asynchronous power-on reset (clears the cause flag) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register address |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read register address |
| rdData | output | 16 | Read data for rdAddr (combinational) |
| resetReq | output | 1 | Reset request to the reset controller |

## Verification
The hardest case to reach is the edge on which the reset request rises while a flag-clear write lands in the same cycle. From the ports, that cycle can only be found by timing the counter exactly. To reach it, the bench loads a reload value of 0, starts the timer and issues the clear write in the very next cycle. On that cycle the counter sits at zero and the set must win. The bench also starts the timer with a small reload value under each of the eight prescaler codes and times the gap to the request. This measures each divider directly instead of inferring it from the counter value.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int CNT_W  = 12;
  localparam int PSC_W  = 3;

  localparam logic [DATA_W-1:0] KEY_OPEN    = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_SERVICE = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;

  typedef enum logic [ADDR_W-1:0] {
    SEL_KEY  = 2'd0,
    SEL_PSC  = 2'd1,
    SEL_RLD  = 2'd2,
    SEL_STAT = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic wrPsc;
    logic wrRld;
  } dpStrobes_t;

endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstSysN,
  input  logic          rstPorN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          reqSet,
  output dpStrobes_t    strb,
  output logic          running,
  output logic          unlocked,
  output logic          causeFlag
);

  logic keyWr;
  logic isStart;
  logic isService;
  logic flagClr;

  assign keyWr     = wrEn && (wrAddr == SEL_KEY);
  assign isStart   = keyWr && (wrData == KEY_START);
  assign isService = keyWr && (wrData == KEY_SERVICE);
  assign flagClr   = wrEn && (wrAddr == SEL_STAT) && wrData[0];

  always_comb begin
    strb         = '0;
    strb.loadCnt = isStart || isService;
    strb.wrPsc   = wrEn && (wrAddr == SEL_PSC) && unlocked;
    strb.wrRld   = wrEn && (wrAddr == SEL_RLD) && unlocked;
  end

  // write-protection state and run state (system reset domain)
  always_ff @(posedge clk or negedge rstSysN) begin
    if (!rstSysN) begin
      unlocked <= 1'b0;
      running  <= 1'b0;
    end else begin
      if (keyWr) unlocked <= (wrData == KEY_OPEN);
      if (isStart) running <= 1'b1;
    end
  end

  // reset-cause flag (power-on domain); setting has priority
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      causeFlag <= 1'b0;
    end else if (reqSet) begin
      causeFlag <= 1'b1;
    end else if (flagClr) begin
      causeFlag <= 1'b0;
    end
  end

  AST_RUN_NO_STOP: assert property (@(posedge clk) disable iff (!rstSysN)
    running |=> running); // R8

  AST_FLAG_ON_REQ: assert property (@(posedge clk) disable iff (!rstSysN || !rstPorN)
    reqSet |=> causeFlag); // R9

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstSysN)
    isStart |=> running); // R4

endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int CW          = CNT_W,
  parameter int PW          = PSC_W,
  parameter int DIV_LOG_MIN = 2,
  parameter int DIV_LOG_MAX = 8
) (
  input  logic          clk,
  input  logic          rstSysN,
  input  dpStrobes_t    strb,
  input  logic          running,
  input  logic [PW-1:0] pscIn,
  input  logic [CW-1:0] rldIn,
  output logic [PW-1:0] pscQ,
  output logic [CW-1:0] rldQ,
  output logic [CW-1:0] cntQ,
  output logic          reqQ,
  output logic          reqSet
);

  localparam int NCODE = 1 << PW;
  localparam int PRE_W = DIV_LOG_MAX;

  logic [PRE_W-1:0] lastPhase [NCODE];
  logic [PRE_W-1:0] preQ;
  logic             tick;

  // terminal phase per prescaler code, saturating at the largest divider
  for (genvar g = 0; g < NCODE; g++) begin : gPhase
    localparam int LOGD = ((g + DIV_LOG_MIN) > DIV_LOG_MAX) ? DIV_LOG_MAX : (g + DIV_LOG_MIN);
    assign lastPhase[g] = PRE_W'((1 << LOGD) - 1);
  end

  assign tick   = preQ >= lastPhase[pscQ];
  assign reqSet = running && (cntQ == '0) && !reqQ;

  always_ff @(posedge clk or negedge rstSysN) begin
    if (!rstSysN) begin
      pscQ <= '0;
      rldQ <= '1;
    end else begin
      if (strb.wrPsc) pscQ <= pscIn;
      if (strb.wrRld) rldQ <= rldIn;
    end
  end

  always_ff @(posedge clk or negedge rstSysN) begin
    if (!rstSysN) begin
      preQ <= '0;
      cntQ <= '1;
    end else if (strb.loadCnt) begin
      preQ <= '0;
      cntQ <= rldQ;
    end else if (running) begin
      if (tick) begin
        preQ <= '0;
        if (cntQ != '0) cntQ <= cntQ - 1'b1;
      end else begin
        preQ <= preQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstSysN) begin
    if (!rstSysN) reqQ <= 1'b0;
    else if (reqSet) reqQ <= 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstSysN)
    (running && !strb.loadCnt) |=> (cntQ == $past(cntQ)) || (cntQ == CW'($past(cntQ) - 1'b1))); // R7

  AST_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rstSysN)
    (running && cntQ == '0) |=> reqQ); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstSysN)
    reqQ |=> reqQ); // R8

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstSysN)
    (!running && !strb.loadCnt) |=> $stable(cntQ)); // R4

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstSysN)
    strb.loadCnt |=> (cntQ == $past(rldQ))); // R5

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W,
  parameter int PW = PSC_W
) (
  input  logic          clk,
  input  logic          rstSysN,
  input  logic          rstPorN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          resetReq
);

  dpStrobes_t    strb;
  logic          running;
  logic          unlocked;
  logic          causeFlag;
  logic          reqSet;
  logic [PW-1:0] pscQ;
  logic [CW-1:0] rldQ;
  logic [CW-1:0] cntQ;

  wdg_ctrl #(.DW(DW), .AW(AW)) uCtrl (
    .clk       (clk),
    .rstSysN   (rstSysN),
    .rstPorN   (rstPorN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .reqSet    (reqSet),
    .strb      (strb),
    .running   (running),
    .unlocked  (unlocked),
    .causeFlag (causeFlag)
  );

  wdg_datapath #(.CW(CW), .PW(PW)) uDp (
    .clk     (clk),
    .rstSysN (rstSysN),
    .strb    (strb),
    .running (running),
    .pscIn   (wrData[PW-1:0]),
    .rldIn   (wrData[CW-1:0]),
    .pscQ    (pscQ),
    .rldQ    (rldQ),
    .cntQ    (cntQ),
    .reqQ    (resetReq),
    .reqSet  (reqSet)
  );

  always_comb begin
    rdData = '0;
    case (rdAddr)
      SEL_KEY:  rdData[CW-1:0] = cntQ;
      SEL_PSC:  rdData[PW-1:0] = pscQ;
      SEL_RLD:  rdData[CW-1:0] = rldQ;
      default:  rdData[2:0]    = {unlocked, running, causeFlag};
    endcase
  end

  AST_LOCKED_PSC: assert property (@(posedge clk) disable iff (!rstSysN)
    (wrEn && wrAddr == SEL_PSC && !unlocked) |=> $stable(pscQ)); // R3

  AST_LOCKED_RLD: assert property (@(posedge clk) disable iff (!rstSysN)
    (wrEn && wrAddr == SEL_RLD && !unlocked) |=> $stable(rldQ)); // R3

  AST_OPEN_PSC: assert property (@(posedge clk) disable iff (!rstSysN)
    (wrEn && wrAddr == SEL_PSC && unlocked) |=> (pscQ == $past(wrData[PW-1:0]))); // R2

  AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!rstSysN || !rstPorN)
    $rose(resetReq) |-> causeFlag); // R9

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

  logic        clk = 1'b0;
  logic        rstSysN, rstPorN;
  logic        wrEn;
  logic [1:0]  wrAddr;
  logic [15:0] wrData;
  logic [1:0]  rdAddr;
  logic [15:0] rdData;
  logic        resetReq;

  int nChk = 0;
  int nErr = 0;
  int cycles = 0;

  // behavioural reference state
  int mRun, mCnt, mPre, mUnl, mPsc, mRld, mFlag, mReq;
  int d;
  bit keyW, load, setF;

  always #5 clk = ~clk;

  keyed_watchdog u0 (
    .clk(clk), .rstSysN(rstSysN), .rstPorN(rstPorN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .resetReq(resetReq)
  );

  function automatic int divOf(int code);
    return 1 << (((code > 6) ? 6 : code) + 2);
  endfunction

  always @(posedge clk) begin
    if (!rstPorN) mFlag = 0;
    if (!rstSysN) begin
      mRun = 0; mCnt = 4095; mPre = 0; mUnl = 0; mPsc = 0; mRld = 4095; mReq = 0;
    end else begin
      keyW = wrEn && wrAddr == 2'd0;
      load = keyW && (wrData == 16'hAAAA || wrData == 16'hCCCC);
      d    = divOf(mPsc);
      setF = (mRun != 0) && mCnt == 0 && mReq == 0;
      if (load) begin
        mCnt = mRld; mPre = 0;
      end else if (mRun != 0) begin
        if (mPre >= d - 1) begin
          mPre = 0;
          if (mCnt != 0) mCnt = mCnt - 1;
        end else mPre = mPre + 1;
      end
      if (setF) mReq = 1;
      if (keyW && wrData == 16'hCCCC) mRun = 1;
      if (wrEn && wrAddr == 2'd1 && mUnl != 0) mPsc = int'(wrData[2:0]);
      if (wrEn && wrAddr == 2'd2 && mUnl != 0) mRld = int'(wrData[11:0]);
      if (keyW) mUnl = (wrData == 16'h5555) ? 1 : 0;
      if (rstPorN) begin
        if (setF) mFlag = 1;
        else if (wrEn && wrAddr == 2'd3 && wrData[0]) mFlag = 0;
      end
    end
  end

  function automatic int expRd(logic [1:0] a);
    case (a)
      2'd0: return mCnt;
      2'd1: return mPsc;
      2'd2: return mRld;
      default: return mFlag + 2 * mRun + 4 * mUnl;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag, input string what);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare against the model at the next negedge
  task automatic cyc(input bit we, input logic [1:0] wa, input logic [15:0] wd, input string tag);
    wrEn = we; wrAddr = wa; wrData = wd;
    rdAddr = rdAddr + 2'd1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    chk(int'(resetReq), mReq, tag, "resetReq vs model");
    chk(int'(rdData), expRd(rdAddr), tag, "rdData vs model");
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 16'h0, tag);
  endtask

  task automatic rdChk(input logic [1:0] a, input int exp, input string tag);
    rdAddr = a;
    #1;
    chk(int'(rdData), exp, tag, "register read");
  endtask

  task automatic measure(input int exp, input string tag);
    int n = 0;
    while (!resetReq && n < 4000) begin
      cyc(0, 2'd0, 16'h0, tag);
      n++;
    end
    chk(n, exp, tag, "edges to reset request");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      nErr++; nChk++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    rstSysN = 1'b0; rstPorN = 1'b0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    @(negedge clk);
    idle(3, "R1");
    rstSysN = 1'b1; rstPorN = 1'b1;
    rdChk(2'd0, 12'hFFF, "R1");
    rdChk(2'd1, 0, "R1");
    rdChk(2'd2, 12'hFFF, "R1");
    rdChk(2'd3, 0, "R1");
    chk(int'(resetReq), 0, "R1", "request after reset");

    // closed writes are ignored
    cyc(1, 2'd1, 16'h0003, "R3");
    rdChk(2'd1, 0, "R3");

    // open and configure
    cyc(1, 2'd0, 16'h5555, "R2");
    rdChk(2'd3, 4, "R2");
    cyc(1, 2'd1, 16'h0001, "R2");
    cyc(1, 2'd2, 16'd20, "R2");
    rdChk(2'd1, 1, "R2");
    rdChk(2'd2, 20, "R2");

    // other keys close writes
    cyc(1, 2'd0, 16'h1234, "R3");
    rdChk(2'd3, 0, "R3");
    cyc(1, 2'd2, 16'd5, "R3");
    rdChk(2'd2, 20, "R3");
    cyc(1, 2'd0, 16'h5555, "R3");
    cyc(1, 2'd0, 16'hAAAA, "R3");
    cyc(1, 2'd1, 16'h0007, "R3");
    rdChk(2'd1, 1, "R3");

    // start with divider 8, reload 20
    cyc(1, 2'd0, 16'hCCCC, "R4");
    rdChk(2'd0, 20, "R4");
    rdChk(2'd3, 2, "R4");
    idle(100, "R5");
    rdChk(2'd0, 8, "R5");
    cyc(1, 2'd0, 16'hAAAA, "R5");
    rdChk(2'd0, 20, "R5");

    // keys cannot stop it
    cyc(1, 2'd0, 16'h0000, "R8");
    cyc(1, 2'd0, 16'h5555, "R8");
    cyc(1, 2'd0, 16'h0001, "R8");
    rdChk(2'd3, 2, "R8");
    measure(20 * 8 + 1 - 3, "R7");
    rdChk(2'd3, 3, "R9");
    idle(5, "R8");
    chk(int'(resetReq), 1, "R8", "request held");

    // system reset keeps the flag
    rstSysN = 1'b0;
    idle(2, "R9");
    rstSysN = 1'b1;
    rdChk(2'd3, 1, "R9");
    chk(int'(resetReq), 0, "R9", "request after system reset");

    // clearing the flag
    cyc(1, 2'd3, 16'h0000, "R10");
    rdChk(2'd3, 1, "R10");
    cyc(1, 2'd3, 16'h0001, "R10");
    rdChk(2'd3, 0, "R10");

    // reload 0: request next edge, clear in the same cycle loses to set
    cyc(1, 2'd0, 16'h5555, "R10");
    cyc(1, 2'd2, 16'h0000, "R10");
    cyc(1, 2'd0, 16'hCCCC, "R7");
    cyc(1, 2'd3, 16'h0001, "R10");
    rdChk(2'd3, 3, "R10");
    chk(int'(resetReq), 1, "R7", "request one edge after zero load");

    // power-on reset clears the flag
    rstSysN = 1'b0; rstPorN = 1'b0;
    idle(2, "R10");
    rstSysN = 1'b1; rstPorN = 1'b1;
    rdChk(2'd3, 0, "R10");

    // divider sweep over every code
    for (int c = 0; c < 8; c++) begin
      rstSysN = 1'b0;
      idle(1, "R6");
      rstSysN = 1'b1;
      cyc(1, 2'd0, 16'h5555, "R6");
      cyc(1, 2'd1, 16'(c), "R6");
      cyc(1, 2'd2, 16'd2, "R6");
      cyc(1, 2'd0, 16'hCCCC, "R6");
      measure(2 * ((c >= 6) ? 256 : (4 << c)) + 1, "R6");
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule